// File: doc/BRIEF.md
# Keyslot Configuration Register File

This block is the device-side storage for inline-encryption slot configurations. Each slot is eighteen 32-bit dwords: sixteen dwords of key material, a control dword that carries the data-unit mask, the capability index and an enable bit, and one extra dword. Software reaches the slots through a plain dword write port and a registered read port, both addressed by slot number and dword offset. A cipher datapath reads a gated per-slot view through a third, combinational port.

Activation follows an ordered sequence. Software clears the control dword, loads key dwords 0 to 15 in order, writes the extra dword, and writes the control dword last with the enable bit set. The block enforces this order: any key or extra write to an enabled slot drops its enable, so the datapath never uses a half-loaded key. Eviction is done by writing zero to all eighteen dwords. The number of slots is a configured count plus one.

Top module: `keyslot_regfile`

## Requirements
- R1: The block has CFG_COUNT+1 slots, numbered 0 to CFG_COUNT inclusive. A write to a slot number above CFG_COUNT changes no state, and a read from one returns zero.
- R2: Inside a slot, offsets 0 to 15 are key dwords, offset 16 is the control dword and offset 17 is the extra dword. Writes to offsets 18 to 31 are dropped, and reads from them return zero.
- R3: The control dword is stored whole. Bits [7:0] are the data-unit mask, bits [15:8] are the capability index and bit 31 is the enable bit.
- R4: A write of the control dword with bit 31 set enables the slot on the next clock edge. The view for that slot then shows view_en=1 and the stored mask and capability index.
- R5: A write to a key dword or to the extra dword of an enabled slot stores the data and clears bit 31 of that slot's control dword. The other control bits keep their values.
- R6: While the viewed slot is not enabled, or its number is out of range, view_en, view_cap_idx, view_du_mask and view_key are all zero.
- R7: Key dword i of an enabled slot appears at view_key[32*i+31:32*i]. Byte 32 (dword 8, bit 256) therefore starts the second half of a split two-part key.
- R8: A read with rd_en high loads rd_data on the next clock edge from the state before that edge. With rd_en low, rd_data holds its value.
- R9: After reset, every dword of every slot reads zero and no slot is enabled.
- R10: Writing zero to all eighteen dwords of a slot evicts it: every dword reads zero and its view is disabled.
- R11: A slot's enable bit is set only by a control dword write to that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Dword write strobe |
| wr_slot | input | SLOT_AW | Slot number for the write |
| wr_dw | input | 5 | Dword offset for the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_slot | input | SLOT_AW | Slot number for the read |
| rd_dw | input | 5 | Dword offset for the read |
| rd_data | output | 32 | Registered read data |
| view_slot | input | SLOT_AW | Slot selected by the datapath |
| view_en | output | 1 | Selected slot is enabled |
| view_cap_idx | output | 8 | Capability index of the selected slot |
| view_du_mask | output | 8 | Data-unit mask of the selected slot |
| view_key | output | 512 | Key area of the selected slot |

## Verification
The assertions assume that wr_en, wr_slot, wr_dw and wr_data are driven to known values at every clock edge after reset. They also assume that at most one write arrives per cycle, so each slot's enable bit is driven only by the one write that hits it. The bench changes inputs only on falling edges and holds every strobe low between operations. Its out-of-range slot and offset writes carry defined data, so the stability properties look only at the drop path.

// File: rtl/kslot_pkg.sv
package kslot_pkg;
  localparam int DWORD_W    = 32;
  localparam int KEY_DWORDS = 16;
  localparam int CTRL_OFF   = 16;
  localparam int EXTRA_OFF  = 17;
  localparam int OFF_W      = 5;
  localparam int KEY_W      = KEY_DWORDS * DWORD_W;
  localparam int EN_BIT     = 31;

  typedef enum logic [1:0] {
    DW_NONE  = 2'd0,
    DW_KEY   = 2'd1,
    DW_CTRL  = 2'd2,
    DW_EXTRA = 2'd3
  } dw_kind_e;

  function automatic dw_kind_e classify_off(input logic [OFF_W-1:0] off);
    if (off < OFF_W'(KEY_DWORDS)) return DW_KEY;
    if (off == OFF_W'(CTRL_OFF))  return DW_CTRL;
    if (off == OFF_W'(EXTRA_OFF)) return DW_EXTRA;
    return DW_NONE;
  endfunction

  function automatic logic ctrl_enable(input logic [DWORD_W-1:0] c);
    return c[EN_BIT];
  endfunction

  function automatic logic [7:0] ctrl_mask(input logic [DWORD_W-1:0] c);
    return c[7:0];
  endfunction

  function automatic logic [7:0] ctrl_cap(input logic [DWORD_W-1:0] c);
    return c[15:8];
  endfunction

  function automatic logic [DWORD_W-1:0] ctrl_drop_enable(input logic [DWORD_W-1:0] c);
    logic [DWORD_W-1:0] r;
    r = c;
    r[EN_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/kslot_wdec.sv
module kslot_wdec
  import kslot_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_AW   = 3
) (
  input  logic                 wr_en,
  input  logic [SLOT_AW-1:0]   wr_slot,
  input  logic [OFF_W-1:0]     wr_dw,
  output logic [NUM_SLOTS-1:0] slot_we,
  output dw_kind_e             wr_kind
);
  assign wr_kind = classify_off(wr_dw);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hit
    assign slot_we[i] = wr_en && (wr_slot == SLOT_AW'(i)) && (wr_kind != DW_NONE);
  end
endmodule

// File: rtl/kslot_entry.sv
module kslot_entry
  import kslot_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  dw_kind_e                         kind,
  input  logic [3:0]                       key_idx,
  input  logic [DWORD_W-1:0]               data,
  output logic [KEY_DWORDS-1:0][DWORD_W-1:0] key_o,
  output logic [DWORD_W-1:0]               ctrl_o,
  output logic [DWORD_W-1:0]               extra_o,
  output logic                             en_o
);
  logic [KEY_DWORDS-1:0][DWORD_W-1:0] key_q;
  logic [DWORD_W-1:0]                 ctrl_q;
  logic [DWORD_W-1:0]                 extra_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q   <= '0;
      ctrl_q  <= '0;
      extra_q <= '0;
    end else if (we) begin
      case (kind)
        DW_KEY: begin
          key_q[key_idx] <= data;
          ctrl_q         <= ctrl_drop_enable(ctrl_q);
        end
        DW_EXTRA: begin
          extra_q <= data;
          ctrl_q  <= ctrl_drop_enable(ctrl_q);
        end
        DW_CTRL: ctrl_q <= data;
        default: ;
      endcase
    end
  end

  assign key_o   = key_q;
  assign ctrl_o  = ctrl_q;
  assign extra_o = extra_q;
  assign en_o    = ctrl_enable(ctrl_q);
endmodule

// File: rtl/kslot_rdmux.sv
module kslot_rdmux
  import kslot_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_AW   = 3
) (
  input  logic [SLOT_AW-1:0]                                  sel_slot,
  input  logic [OFF_W-1:0]                                    sel_dw,
  input  logic [NUM_SLOTS-1:0][KEY_DWORDS-1:0][DWORD_W-1:0]   key_all,
  input  logic [NUM_SLOTS-1:0][DWORD_W-1:0]                   ctrl_all,
  input  logic [NUM_SLOTS-1:0][DWORD_W-1:0]                   extra_all,
  output logic [DWORD_W-1:0]                                  dout
);
  dw_kind_e kind;
  assign kind = classify_off(sel_dw);

  always_comb begin
    dout = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (sel_slot == SLOT_AW'(i)) begin
        case (kind)
          DW_KEY:   dout = key_all[i][sel_dw[3:0]];
          DW_CTRL:  dout = ctrl_all[i];
          DW_EXTRA: dout = extra_all[i];
          default:  dout = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/keyslot_regfile.sv
module keyslot_regfile
  import kslot_pkg::*;
#(
  parameter int CFG_COUNT = 3,
  parameter int NUM_SLOTS = CFG_COUNT + 1,
  parameter int SLOT_AW   = $clog2(NUM_SLOTS) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SLOT_AW-1:0] wr_slot,
  input  logic [4:0]         wr_dw,
  input  logic [31:0]        wr_data,
  input  logic               rd_en,
  input  logic [SLOT_AW-1:0] rd_slot,
  input  logic [4:0]         rd_dw,
  output logic [31:0]        rd_data,
  input  logic [SLOT_AW-1:0] view_slot,
  output logic               view_en,
  output logic [7:0]         view_cap_idx,
  output logic [7:0]         view_du_mask,
  output logic [511:0]       view_key
);
  logic [NUM_SLOTS-1:0]                                slot_we;
  dw_kind_e                                            wr_kind;
  logic [NUM_SLOTS-1:0][KEY_DWORDS-1:0][DWORD_W-1:0]   key_all;
  logic [NUM_SLOTS-1:0][DWORD_W-1:0]                   ctrl_all;
  logic [NUM_SLOTS-1:0][DWORD_W-1:0]                   extra_all;
  logic [NUM_SLOTS-1:0]                                slot_en_vec;
  logic [DWORD_W-1:0]                                  rd_mux;

  kslot_wdec #(.NUM_SLOTS(NUM_SLOTS), .SLOT_AW(SLOT_AW)) u_wdec (
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_dw   (wr_dw),
    .slot_we (slot_we),
    .wr_kind (wr_kind)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    kslot_entry u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (slot_we[i]),
      .kind    (wr_kind),
      .key_idx (wr_dw[3:0]),
      .data    (wr_data),
      .key_o   (key_all[i]),
      .ctrl_o  (ctrl_all[i]),
      .extra_o (extra_all[i]),
      .en_o    (slot_en_vec[i])
    );
  end

  kslot_rdmux #(.NUM_SLOTS(NUM_SLOTS), .SLOT_AW(SLOT_AW)) u_rdmux (
    .sel_slot  (rd_slot),
    .sel_dw    (rd_dw),
    .key_all   (key_all),
    .ctrl_all  (ctrl_all),
    .extra_all (extra_all),
    .dout      (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  always_comb begin
    view_en      = 1'b0;
    view_cap_idx = '0;
    view_du_mask = '0;
    view_key     = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (view_slot == SLOT_AW'(i) && slot_en_vec[i]) begin
        view_en      = 1'b1;
        view_cap_idx = ctrl_cap(ctrl_all[i]);
        view_du_mask = ctrl_mask(ctrl_all[i]);
        view_key     = key_all[i];
      end
    end
  end
endmodule

// File: rtl/kslot_regfile_chk.sv
module kslot_regfile_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_AW   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [SLOT_AW-1:0]   wr_slot,
  input logic [4:0]           wr_dw,
  input logic [31:0]          wr_data,
  input logic [NUM_SLOTS-1:0] slot_en_vec,
  input logic                 view_en,
  input logic [7:0]           view_cap_idx,
  input logic [7:0]           view_du_mask,
  input logic [511:0]         view_key
);
  logic oor_wr;
  assign oor_wr = wr_en && (wr_slot >= SLOT_AW'(NUM_SLOTS));

  // R6: a disabled view exposes nothing
  assert_view_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !view_en |-> (view_key == '0 && view_cap_idx == 8'd0 && view_du_mask == 8'd0));

  // R1: out-of-range writes leave every enable unchanged
  assert_oor_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    oor_wr |=> $stable(slot_en_vec));

  // R2: writes to unmapped offsets leave every enable unchanged
  assert_bad_off_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dw > 5'd17) |=> $stable(slot_en_vec));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_prop
    logic hit, hit_key, hit_ctrl;
    assign hit      = wr_en && (wr_slot == SLOT_AW'(i));
    assign hit_key  = hit && (wr_dw < 5'd16 || wr_dw == 5'd17);
    assign hit_ctrl = hit && (wr_dw == 5'd16);

    // R5: key or extra write always leaves the slot disabled
    assert_key_drops_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_key |=> !slot_en_vec[i]);

    // R4: control write sets enable from its bit 31
    assert_ctrl_sets_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ctrl |=> (slot_en_vec[i] == $past(wr_data[31])));

    // R11: enable rises only through a control write
    assert_en_only_ctrl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_en_vec[i] && !hit_ctrl) |=> !slot_en_vec[i]);
  end
endmodule

bind keyslot_regfile kslot_regfile_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_AW(SLOT_AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_slot      (wr_slot),
  .wr_dw        (wr_dw),
  .wr_data      (wr_data),
  .slot_en_vec  (slot_en_vec),
  .view_en      (view_en),
  .view_cap_idx (view_cap_idx),
  .view_du_mask (view_du_mask),
  .view_key     (view_key)
);

// File: tb/sim_keyslot_regfile.sv
`timescale 1ns/1ps
module sim_keyslot_regfile;
  localparam int CFG_COUNT = 3;
  localparam int NSLOT     = CFG_COUNT + 1;
  localparam int SAW       = $clog2(NSLOT) + 1;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en, rd_en;
  logic [SAW-1:0] wr_slot, rd_slot, view_slot;
  logic [4:0]     wr_dw, rd_dw;
  logic [31:0]    wr_data, rd_data;
  logic           view_en;
  logic [7:0]     view_cap_idx, view_du_mask;
  logic [511:0]   view_key;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  keyslot_regfile #(.CFG_COUNT(CFG_COUNT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_dw(wr_dw), .wr_data(wr_data),
    .rd_en(rd_en), .rd_slot(rd_slot), .rd_dw(rd_dw), .rd_data(rd_data),
    .view_slot(view_slot), .view_en(view_en), .view_cap_idx(view_cap_idx),
    .view_du_mask(view_du_mask), .view_key(view_key)
  );

  function automatic logic [31:0] kpat(input int s, input int i);
    return 32'hA500_0000 | (s << 12) | (i << 4) | 32'h3;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int s, input int d, input logic [31:0] v);
    wr_en = 1'b1; wr_slot = SAW'(s); wr_dw = 5'(d); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int s, input int d, output logic [31:0] v);
    rd_en = 1'b1; rd_slot = SAW'(s); rd_dw = 5'(d);
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic load_slot(input int s, input logic [31:0] ctrl);
    wr(s, 16, 32'h0);
    for (int i = 0; i < 16; i++) wr(s, i, kpat(s, i));
    wr(s, 17, 32'h5EED_0000 | s);
    wr(s, 16, ctrl);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int s = 0; s < NSLOT; s++) begin
      rd(s, 0, v);  chk("R9 key0", v, 32'h0);
      rd(s, 16, v); chk("R9 ctrl", v, 32'h0);
      view_slot = SAW'(s); #1;
      chk("R9 view_en", {31'h0, view_en}, 32'h0);
    end
  endtask

  task automatic t_program;
    logic [31:0] v;
    view_slot = SAW'(1);
    wr(1, 16, 32'h0);
    for (int i = 0; i < 16; i++) wr(1, i, kpat(1, i));
    wr(1, 17, 32'h5EED_0001);
    #1 chk("R11 not enabled before ctrl", {31'h0, view_en}, 32'h0);
    wr(1, 16, 32'h8000_0A04);
    #1;
    chk("R4 view_en", {31'h0, view_en}, 32'h1);
    chk("R3 cap idx", {24'h0, view_cap_idx}, 32'h0A);
    chk("R3 du mask", {24'h0, view_du_mask}, 32'h04);
    chk("R7 dword0", view_key[31:0], kpat(1, 0));
    chk("R7 dword8 at bit256", view_key[287:256], kpat(1, 8));
    chk("R7 dword15", view_key[511:480], kpat(1, 15));
    rd(1, 16, v); chk("R3 ctrl stored whole", v, 32'h8000_0A04);
    rd(1, 17, v); chk("R2 extra", v, 32'h5EED_0001);
    rd(1, 5, v);  chk("R2 key5", v, kpat(1, 5));
  endtask

  task automatic t_key_drops_enable;
    logic [31:0] v;
    view_slot = SAW'(1);
    wr(1, 3, 32'hDEAD_BEEF);
    #1 chk("R5 en cleared by key write", {31'h0, view_en}, 32'h0);
    chk("R6 key gated", view_key[127:96], 32'h0);
    chk("R6 cap gated", {24'h0, view_cap_idx}, 32'h0);
    rd(1, 16, v); chk("R5 ctrl other bits kept", v, 32'h0000_0A04);
    rd(1, 3, v);  chk("R5 key data stored", v, 32'hDEAD_BEEF);
    wr(1, 16, 32'h8000_0A04);
    #1 chk("R4 re-enable", {31'h0, view_en}, 32'h1);
    wr(1, 17, 32'h1234_5678);
    #1 chk("R5 en cleared by extra write", {31'h0, view_en}, 32'h0);
    rd(1, 17, v); chk("R5 extra stored", v, 32'h1234_5678);
  endtask

  task automatic t_out_of_range;
    logic [31:0] v;
    load_slot(CFG_COUNT, 32'h8000_0301);
    view_slot = SAW'(CFG_COUNT); #1;
    chk("R1 top slot enables", {31'h0, view_en}, 32'h1);
    wr(NSLOT, 16, 32'h8000_FFFF);
    wr(7, 0, 32'hFFFF_FFFF);
    rd(NSLOT, 16, v); chk("R1 oor read ctrl", v, 32'h0);
    rd(7, 0, v);      chk("R1 oor read key", v, 32'h0);
    rd(0, 16, v);     chk("R1 slot0 untouched", v, 32'h0);
    rd(CFG_COUNT, 0, v); chk("R1 top slot key kept", v, kpat(CFG_COUNT, 0));
    view_slot = SAW'(NSLOT); #1;
    chk("R6 oor view", {31'h0, view_en}, 32'h0);
  endtask

  task automatic t_bad_offset;
    logic [31:0] v;
    view_slot = SAW'(CFG_COUNT);
    wr(CFG_COUNT, 20, 32'hCAFE_F00D);
    wr(CFG_COUNT, 31, 32'h0);
    #1 chk("R2 bad offset keeps enable", {31'h0, view_en}, 32'h1);
    rd(CFG_COUNT, 20, v); chk("R2 bad offset reads zero", v, 32'h0);
    rd(CFG_COUNT, 16, v); chk("R2 ctrl unchanged", v, 32'h8000_0301);
  endtask

  task automatic t_read_hold;
    logic [31:0] v;
    rd(CFG_COUNT, 16, v);
    rd_slot = SAW'(CFG_COUNT); rd_dw = 5'd0;
    @(negedge clk);
    chk("R8 rd_data holds with rd_en low", rd_data, 32'h8000_0301);
  endtask

  task automatic t_evict;
    logic [31:0] v;
    bit bad;
    for (int d = 0; d < 18; d++) wr(CFG_COUNT, d, 32'h0);
    view_slot = SAW'(CFG_COUNT); #1;
    chk("R10 view disabled", {31'h0, view_en}, 32'h0);
    bad = 1'b0;
    for (int d = 0; d < 18; d++) begin
      rd(CFG_COUNT, d, v);
      if (v !== 32'h0) begin bad = 1'b1; chk("R10 dword zero", v, 32'h0); end
    end
    if (!bad) chk("R10 all dwords zero", 32'h0, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_slot = '0; rd_slot = '0; view_slot = '0;
    wr_dw = '0; rd_dw = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_key_drops_enable();
    t_out_of_range();
    t_bad_offset();
    t_read_hold();
    t_evict();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule